// File: doc/BRIEF.md
# Cycle-Synchronous RMS Accumulator

This block turns a stream of signed samples, taken a whole number of times per line cycle, into one RMS reading per measurement window. Each sample is squared and summed. A window covers a programmable number of whole line cycles. When the window's last sample arrives, the block divides the sum of squares by the window's sample count to get the mean square. It then takes the integer square root of the mean square and presents the result with a one-cycle valid pulse.

An external strobe generator locks the sample rate to the line, so that each line cycle has exactly `spc` samples. The same generator raises a cycle marker together with the first sample of each cycle. The window therefore always spans whole cycles, and the reading does not depend on where sampling starts relative to the zero crossing.

The cost of the division depends on the window length. When the window length is a power of two, the division is a shift. For any other length, a sequential restoring divider does the division. A marker that arrives on a sample that is not the first of a cycle means the generator has lost lock. In that case the block discards the partial sum, starts a new window at that sample, and raises a sticky error flag.

If a window closes while the previous result is still being computed, the block drops the old computation and starts on the new window.

Top module: `cyc_rms`

## Requirements
- R1: After reset, the block ignores every sample until one arrives with `smp_first` high. That marked sample is the first sample of the first window.
- R2: A window holds `spc*ncyc` samples (both inputs nonzero and stable). At its end, `rms` becomes floor(sqrt(floor(S/N))), where S is the sum of the squared signed samples and N is `spc*ncyc`. The next window begins with the next sample. A marker on the first sample of a cycle is expected and changes nothing.
- R3: With 8 samples per cycle of a sine of amplitude 100, rounded to integers, the result is 70 both when sampling starts at 0 degrees and when it starts at 22.5 degrees.
- R4: A window of several cycles (`ncyc` > 1) averages all `spc*ncyc` samples into one result.
- R5: The sum does not overflow. With every sample at -2^(SW-1) and the largest `spc` and `ncyc`, the result is exactly 2^(SW-1).
- R6: When N is a power of two, `rms_vld` rises exactly SW clock cycles after the edge that accepted the window's last sample.
- R7: When N is not a power of two, `rms_vld` rises exactly ACCW+SW cycles after that edge. Here ACCW = 2*SW + NW, and NW = clog2((2^SPC_W-1)*(2^CYC_W-1)+1).
- R8: `rms_vld` is a single-cycle pulse. `rms` holds its value until the next result.
- R9: A marker on a sample whose position within its cycle is not 0 does three things. It discards the partial window, starts a new window with that sample, and sets `resync_err`. `resync_err` stays high until reset.
- R10: While reset is asserted and just after it is released, `rms` is 0, `rms_vld` is 0 and `resync_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | SW | Signed sample |
| smp_first | input | 1 | Cycle marker, qualified by `smp_vld` |
| spc | input | SPC_W | Samples per line cycle |
| ncyc | input | CYC_W | Line cycles per window |
| rms | output | SW | Unsigned RMS result |
| rms_vld | output | 1 | One-cycle result strobe |
| resync_err | output | 1 | Sticky lost-lock flag |

## Verification
A wrong sample count or cycle position shows up at the first result of a window, either as a changed value or as a result at the wrong moment. A position error also shows up at the first mid-cycle marker, as a false or missing `resync_err`. Faults in the divider or the root show up in the value of the very next result. A change in the number of iterations moves `rms_vld` off the exact latency of SW cycles or ACCW+SW cycles. The bench sweeps every window length over a small configuration, and it compares each result and each latency with values it computes from the samples it drove.

// File: rtl/cyc_rms.sv
module cyc_rms #(
  parameter int SW    = 12,
  parameter int SPC_W = 8,
  parameter int CYC_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp,
  input  logic                 smp_first,
  input  logic [SPC_W-1:0]     spc,
  input  logic [CYC_W-1:0]     ncyc,
  output logic [SW-1:0]        rms,
  output logic                 rms_vld,
  output logic                 resync_err
);
  localparam int NMAX = ((1 << SPC_W) - 1) * ((1 << CYC_W) - 1);
  localparam int NW   = $clog2(NMAX + 1);
  localparam int ACCW = 2 * SW + NW;
  localparam int MW   = 2 * SW;
  localparam int DCW  = $clog2(ACCW);
  localparam int BW   = $clog2(SW);
  localparam int LGW  = $clog2(NW);

  typedef enum logic [1:0] {C_IDLE, C_DIV, C_ROOT} cst_t;

  logic             armed;
  logic [ACCW-1:0]  acc;
  logic [NW-1:0]    cnt;
  logic [SPC_W-1:0] pos;

  logic [NW-1:0]    nwin;
  logic signed [MW-1:0] sx, sqs;
  logic [ACCW-1:0]  acc_n;
  logic [NW-1:0]    cnt_n;
  logic [SPC_W-1:0] pos_inc, pos_n;
  logic             restart, take, close, pow2;
  logic [LGW-1:0]   lg;

  assign nwin    = NW'(spc) * NW'(ncyc);
  assign sx      = {{SW{smp[SW-1]}}, smp};
  assign sqs     = sx * sx;
  assign restart = smp_vld && smp_first && (!armed || pos != '0);
  assign take    = smp_vld && (armed || smp_first);
  assign acc_n   = (restart ? '0 : acc) + ACCW'(unsigned'(sqs));
  assign cnt_n   = (restart ? '0 : cnt) + 1'b1;
  assign pos_inc = (restart ? '0 : pos) + 1'b1;
  assign pos_n   = (pos_inc == spc) ? '0 : pos_inc;
  assign close   = take && (cnt_n == nwin);
  assign pow2    = (nwin & (nwin - 1'b1)) == '0;

  always_comb begin
    lg = '0;
    for (int i = 0; i < NW; i++)
      if (nwin[i]) lg = LGW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      acc        <= '0;
      cnt        <= '0;
      pos        <= '0;
      resync_err <= 1'b0;
    end else if (take) begin
      armed <= 1'b1;
      if (restart && armed) resync_err <= 1'b1;
      if (close) begin
        acc <= '0;
        cnt <= '0;
        pos <= '0;
      end else begin
        acc <= acc_n;
        cnt <= cnt_n;
        pos <= pos_n;
      end
    end
  end

  cst_t            st;
  logic [ACCW-1:0] q;
  logic [NW-1:0]   rem, den;
  logic [DCW-1:0]  dcnt;
  logic [MW-1:0]   mean;
  logic [SW-1:0]   root;
  logic [BW-1:0]   bitk;

  logic [NW:0]     rem_s;
  logic            ge;
  logic [SW-1:0]   trial, root_n;
  logic [MW-1:0]   tsq;

  assign rem_s  = {rem, q[ACCW-1]};
  assign ge     = rem_s >= {1'b0, den};
  assign trial  = root | (SW'(1) << bitk);
  assign tsq    = MW'(trial) * MW'(trial);
  assign root_n = (tsq <= mean) ? trial : root;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      q       <= '0;
      rem     <= '0;
      den     <= '0;
      dcnt    <= '0;
      mean    <= '0;
      root    <= '0;
      bitk    <= '0;
      rms     <= '0;
      rms_vld <= 1'b0;
    end else begin
      rms_vld <= 1'b0;
      if (close) begin
        if (pow2) begin
          mean <= MW'(acc_n >> lg);
          root <= '0;
          bitk <= BW'(SW - 1);
          st   <= C_ROOT;
        end else begin
          q    <= acc_n;
          rem  <= '0;
          den  <= nwin;
          dcnt <= DCW'(ACCW - 1);
          st   <= C_DIV;
        end
      end else begin
        case (st)
          C_DIV: begin
            q   <= {q[ACCW-2:0], ge};
            rem <= ge ? NW'(rem_s - {1'b0, den}) : NW'(rem_s);
            if (dcnt == '0) begin
              mean <= MW'({q[ACCW-2:0], ge});
              root <= '0;
              bitk <= BW'(SW - 1);
              st   <= C_ROOT;
            end else begin
              dcnt <= dcnt - 1'b1;
            end
          end
          C_ROOT: begin
            if (bitk == '0) begin
              rms     <= root_n;
              rms_vld <= 1'b1;
              st      <= C_IDLE;
            end else begin
              root <= root_n;
              bitk <= bitk - 1'b1;
            end
          end
          default: st <= C_IDLE;
        endcase
      end
    end
  end

  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rms_vld |=> !rms_vld);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resync_err |=> resync_err);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !restart) |-> (acc_n >= acc));
  assert_result_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rms_vld |-> (rms <= SW'(1 << (SW - 1))));
  assert_count_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && nwin != '0) |-> (cnt < nwin));
  assert_root_after_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DIV && dcnt == '0 && !close) |=> (st == C_ROOT));
endmodule

// File: tb/test_cyc_rms.sv
`timescale 1ns/1ps
module test_cyc_rms;
  localparam int SW = 8, SPC_W = 5, CYC_W = 3;
  localparam int NW = 8, ACCW = 2 * SW + NW;

  logic clk = 0, rst_n = 0, smp_vld = 0, smp_first = 0;
  logic signed [SW-1:0] smp = '0;
  logic [SPC_W-1:0] spc = 5'd8;
  logic [CYC_W-1:0] ncyc = 3'd1;
  logic [SW-1:0] rms;
  logic rms_vld, resync_err;

  int errs = 0, checks = 0;
  int s_arr [0:255];

  cyc_rms #(.SW(SW), .SPC_W(SPC_W), .CYC_W(CYC_W)) i_cyc_rms (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .smp_first(smp_first),
    .spc(spc), .ncyc(ncyc), .rms(rms), .rms_vld(rms_vld), .resync_err(resync_err));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int v, input bit f);
    @(negedge clk);
    smp = SW'(v); smp_first = f; smp_vld = 1;
    @(negedge clk);
    smp_vld = 0; smp_first = 0;
  endtask

  function automatic longint expect_rms(input int n);
    longint s = 0, m, r = 0;
    for (int i = 0; i < n; i++) s += longint'(s_arr[i]) * s_arr[i];
    m = s / n;
    while ((r + 1) * (r + 1) <= m) r++;
    return r;
  endfunction

  task automatic wait_res(output longint got, output int lat);
    got = -1; lat = -1;
    for (int j = 0; j < 200; j++) begin
      if (rms_vld) begin got = rms; lat = j; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input int sp, input int nc, input int first_mark,
                     output longint got, output int lat);
    spc = SPC_W'(sp); ncyc = CYC_W'(nc);
    for (int i = 0; i < sp * nc; i++) send(s_arr[i], (i % sp) == 0 && i >= first_mark);
    wait_res(got, lat);
  endtask

  task automatic win_check(input int sp, input int nc, input string req);
    longint got, exp; int lat;
    exp = expect_rms(sp * nc);
    run(sp, nc, 0, got, lat);
    check(got == exp, req, got, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    longint got, got0, got1, exp; int lat;
    repeat (3) @(negedge clk);
    check(rms == 0 && rms_vld == 0 && resync_err == 0, "R10", {rms_vld, rms}, 0);
    rst_n = 1;
    @(negedge clk);
    check(rms == 0 && rms_vld == 0 && resync_err == 0, "R10", {resync_err, rms_vld, rms}, 0);

    // R1: unmarked samples before the first marker are ignored
    for (int i = 0; i < 5; i++) send(120, 0);
    wait_res(got, lat);
    check(got == -1, "R1 no result before marker", got, -1);
    for (int i = 0; i < 8; i++) s_arr[i] = 3;
    run(8, 1, 0, got, lat);
    check(got == 3, "R1 first window", got, 3);
    check(lat == SW, "R6 pow2 latency", lat, SW);
    @(negedge clk);
    check(rms_vld == 0, "R8 pulse width", rms_vld, 0);
    check(rms == 3, "R8 result held", rms, 3);

    // R3: phase independence
    for (int i = 0; i < 8; i++) s_arr[i] = $rtoi($floor(100.0 * $sin(6.283185307 * i / 8.0) + 0.5));
    exp = expect_rms(8);
    run(8, 1, 0, got0, lat);
    check(got0 == exp && exp == 70, "R3 phase 0", got0, 70);
    for (int i = 0; i < 8; i++) s_arr[i] = $rtoi($floor(100.0 * $sin(6.283185307 * (i + 0.5) / 8.0) + 0.5));
    exp = expect_rms(8);
    run(8, 1, 0, got1, lat);
    check(got1 == exp && exp == 70, "R3 phase 22.5", got1, 70);
    check(got0 == got1, "R3 equal", got1, got0);

    // R7: non power of two length through the divider
    for (int i = 0; i < 6; i++) s_arr[i] = 10 * i - 27;
    exp = expect_rms(6);
    run(6, 1, 0, got, lat);
    check(got == exp, "R2 divider value", got, exp);
    check(lat == ACCW + SW, "R7 divider latency", lat, ACCW + SW);

    // R4: multi-cycle windows
    for (int i = 0; i < 32; i++) s_arr[i] = (i * 29) % 200 - 100;
    win_check(8, 4, "R4 pow2 4 cycles");
    for (int i = 0; i < 15; i++) s_arr[i] = (i * 53) % 251 - 125;
    win_check(5, 3, "R4 3 cycles");

    // R5: full scale, longest window
    for (int i = 0; i < 217; i++) s_arr[i] = -128;
    win_check(31, 7, "R5 full scale");
    check(resync_err == 0, "R9 no false error", resync_err, 0);

    // R2: sweep of window lengths
    for (int sp = 1; sp <= 12; sp++)
      for (int nc = 1; nc <= 3; nc++) begin
        for (int i = 0; i < sp * nc; i++) s_arr[i] = ((i * 37 + sp * 11 + nc * 5) % 256) - 128;
        win_check(sp, nc, "R2 sweep");
      end

    // R9: mid-cycle marker restarts the window
    spc = 5'd8; ncyc = 3'd1;
    send(100, 1); send(-100, 0); send(90, 0);
    for (int i = 0; i < 8; i++) s_arr[i] = 7 + i;
    exp = expect_rms(8);
    run(8, 1, 0, got, lat);
    check(got == exp, "R9 restart value", got, exp);
    check(resync_err == 1, "R9 flag set", resync_err, 1);
    for (int i = 0; i < 8; i++) s_arr[i] = 4;
    run(8, 1, 0, got, lat);
    check(got == 4, "R9 recovery", got, 4);
    check(resync_err == 1, "R9 sticky", resync_err, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule